// File: doc/BRIEF.md
# Timer Software Event Generator

A 16-bit up-counting timer with a prescaler and sixteen capture/compare channels. Software reaches it through a simple register bus: one write per cycle, with an address and a 32-bit data word. Combinational read data is returned for the address on the bus. A write-only strobe register lets software force hardware events. Its bit 0 forces an update: the counter returns to zero, the prescaler divider restarts, and the pending prescaler ratio becomes active. Each of its bits 1 to 16 forces an event on channel 0 to 15.

A forced event on a channel set to input mode copies the live counter into that channel's capture register and sets its flag. On a channel set to output mode it only sets the flag. The flags are sticky and drive per-channel interrupt lines through per-channel enables. The counter advances once every prescaler+1 clocks. When it wraps from 0xFFFF to 0 it raises the update flag and loads the pending prescaler ratio.

Top module: `tim_evgen`

## Requirements
- R1: After reset the counter (0x14), prescaler (0x18), status (0x08) and every capture register (0x20 + 4*n) read 0, and upd_irq_o and ch_irq_o are low.
- R2: After an update event, the counter advances by one on every (P+1)-th clock, where P is the active prescaler ratio. A channel event issued on the (d+1)-th write cycle after the update cycle therefore captures d/(P+1), rounded down.
- R3: Writing bit 0 of the event register (0x10) zeroes the counter and the prescaler divider, activates the pending prescaler value, and sets status bit 0 (the update flag).
- R4: A prescaler value written to 0x18 does not change the count rate until the next update event, either a forced update or a wrap.
- R5: The counter wraps from 0xFFFF to 0x0000 and sets status bit 0 on that wrap.
- R6: Writing bit n+1 of the event register when bit n of the mode register (0x00, 1 = input) is set loads the counter value from before that edge into capture register n. It also sets status bit n+1.
- R7: Writing bit n+1 of the event register when channel n is in output mode (mode bit 0) sets status bit n+1 and leaves capture register n unchanged.
- R8: The event register reads 0. Writing 0 to it has no effect: no flag is set and the counter is not reset.
- R9: Several event bits written in one cycle all take effect on that same edge. A capture in the same write as an update receives the counter value from before the reset.
- R10: Status flags are sticky. Writing 0 to a status bit clears it and writing 1 leaves it unchanged. A hardware set in the same cycle as a software clear leaves the flag set.
- R11: ch_irq_o[n] is status bit n+1 ANDed with enable bit n+1 of the register at 0x04. upd_irq_o is status bit 0 ANDed with enable bit 0.
- R12: The counter register is readable and writable in bits 15:0, and bits 31:16 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| upd_irq_o | output | 1 | Update interrupt |
| ch_irq_o | output | 16 | Per-channel interrupt |

## Verification
The assertions assume that the bus performs at most one register write per cycle. Under that assumption a counter write can never coincide with a forced update, and a capture register write can never coincide with that channel's forced event. They also assume that address, data and strobe are free of unknown values once reset is released.

The bench drives every access from a task that changes the inputs only at falling edges. Each access is a single write or a combinational read, so the stimulus stays inside those assumptions. The bench sweeps all channels in both modes under four prescaler ratios and at varied delays after an update.

// File: rtl/tim_evgen_pkg.sv
package tim_evgen_pkg;
  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_IE   = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_EGR  = 8'h10;
  localparam logic [7:0] OFS_CNT  = 8'h14;
  localparam logic [7:0] OFS_PSC  = 8'h18;
  localparam logic [7:0] OFS_CCR0 = 8'h20;
endpackage

// File: rtl/tim_evgen_timebase.sv
module tim_evgen_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ug_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic [PSC_W-1:0] psc_pre_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [PSC_W-1:0] psc_cnt_q, psc_act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick   = (psc_cnt_q == psc_act_q);
  assign wrap_o = tick && (&cnt_q) && !cnt_we_i && !ug_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_cnt_q <= '0;
      psc_act_q <= '0;
      cnt_q     <= '0;
    end else if (ug_i) begin
      psc_cnt_q <= '0;
      psc_act_q <= psc_pre_i;
      cnt_q     <= '0;
    end else begin
      psc_cnt_q <= tick ? '0 : psc_cnt_q + 1'b1;
      if (wrap_o) psc_act_q <= psc_pre_i;
      if (cnt_we_i)  cnt_q <= cnt_wdata_i;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  a_r3_ug_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug_i |=> (cnt_q == '0) && (psc_cnt_q == '0));
  // R2
  a_r2_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ug_i && !cnt_we_i && !tick) |=> $stable(cnt_q));
  // R5
  a_r5_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  // R4
  a_r4_ratio_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ug_i && !wrap_o) |=> $stable(psc_act_q));
endmodule

// File: rtl/tim_evgen_channel.sv
module tim_evgen_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_in_i,
  input  logic             gen_i,
  input  logic             ccr_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] ccr_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] ccr_q;
  logic             flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccr_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr_i) | gen_i;  // hardware set wins
      if (gen_i && mode_in_i) ccr_q <= cnt_i;
      else if (ccr_we_i)      ccr_q <= wdata_i;
    end
  end

  assign ccr_o  = ccr_q;
  assign flag_o = flag_q;

  // R6
  a_r6_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_i && mode_in_i) |=> (ccr_q == $past(cnt_i)));
  // R7
  a_r7_output_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_i && !mode_in_i && !ccr_we_i) |=> $stable(ccr_q));
  // R10
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_i |=> flag_q);
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/tim_evgen.sv
module tim_evgen
  import tim_evgen_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              upd_irq_o,
  output logic [N_CH-1:0]   ch_irq_o
);
  localparam int FLG_W = N_CH + 1;

  logic [N_CH-1:0]  mode_q;
  logic [FLG_W-1:0] ie_q;
  logic [PSC_W-1:0] psc_q;
  logic             uflag_q;
  logic [FLG_W-1:0] egr, stat_clr;
  logic             sel_mode, sel_ie, sel_stat, sel_egr, sel_cnt, sel_psc;
  logic [CNT_W-1:0] cnt;
  logic             wrap, upd_evt;
  logic [N_CH-1:0]  ch_flag, ccr_we;
  logic [CNT_W-1:0] ccr [N_CH];
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[31:FLG_W];

  assign sel_mode = wr_en_i && (addr_i == ADDR_W'(OFS_MODE));
  assign sel_ie   = wr_en_i && (addr_i == ADDR_W'(OFS_IE));
  assign sel_stat = wr_en_i && (addr_i == ADDR_W'(OFS_STAT));
  assign sel_egr  = wr_en_i && (addr_i == ADDR_W'(OFS_EGR));
  assign sel_cnt  = wr_en_i && (addr_i == ADDR_W'(OFS_CNT));
  assign sel_psc  = wr_en_i && (addr_i == ADDR_W'(OFS_PSC));

  assign egr      = sel_egr  ? wdata_i[FLG_W-1:0]  : '0;
  assign stat_clr = sel_stat ? ~wdata_i[FLG_W-1:0] : '0;
  assign upd_evt  = egr[0] | wrap;

  tim_evgen_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_timebase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ug_i        (egr[0]),
    .cnt_we_i    (sel_cnt),
    .cnt_wdata_i (wdata_i[CNT_W-1:0]),
    .psc_pre_i   (psc_q),
    .cnt_o       (cnt),
    .wrap_o      (wrap)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign ccr_we[i] = wr_en_i && (addr_i == ADDR_W'(OFS_CCR0 + 4 * i));
    tim_evgen_channel #(.CNT_W(CNT_W)) i_channel (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_in_i (mode_q[i]),
      .gen_i     (egr[i+1]),
      .ccr_we_i  (ccr_we[i]),
      .wdata_i   (wdata_i[CNT_W-1:0]),
      .cnt_i     (cnt),
      .clr_i     (stat_clr[i+1]),
      .ccr_o     (ccr[i]),
      .flag_o    (ch_flag[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      ie_q    <= '0;
      psc_q   <= '0;
      uflag_q <= 1'b0;
    end else begin
      if (sel_mode) mode_q <= wdata_i[N_CH-1:0];
      if (sel_ie)   ie_q   <= wdata_i[FLG_W-1:0];
      if (sel_psc)  psc_q  <= wdata_i[PSC_W-1:0];
      uflag_q <= (uflag_q & ~stat_clr[0]) | upd_evt;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_MODE): rdata_o[N_CH-1:0]  = mode_q;
      ADDR_W'(OFS_IE):   rdata_o[FLG_W-1:0] = ie_q;
      ADDR_W'(OFS_STAT): rdata_o[FLG_W-1:0] = {ch_flag, uflag_q};
      ADDR_W'(OFS_CNT):  rdata_o[CNT_W-1:0] = cnt;
      ADDR_W'(OFS_PSC):  rdata_o[PSC_W-1:0] = psc_q;
      default: ;
    endcase
    for (int i = 0; i < N_CH; i++)
      if (addr_i == ADDR_W'(OFS_CCR0 + 4 * i)) rdata_o[CNT_W-1:0] = ccr[i];
  end

  assign upd_irq_o = uflag_q & ie_q[0];
  assign ch_irq_o  = ch_flag & ie_q[FLG_W-1:1];

  // R3 R5
  a_r3_update_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_evt |=> uflag_q);
  // R10
  a_r10_uflag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uflag_q && !stat_clr[0]) |=> uflag_q);
endmodule

// File: tb/test_tim_evgen.sv
module test_tim_evgen;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam logic [7:0] A_MODE = 8'h00, A_IE = 8'h04, A_STAT = 8'h08, A_EGR = 8'h10,
                         A_CNT = 8'h14, A_PSC = 8'h18, A_CCR0 = 8'h20;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        upd_irq;
  logic [15:0] ch_irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tim_evgen i_tim_evgen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .upd_irq_o(upd_irq), .ch_irq_o(ch_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] ccr_addr(input int ch);
    return 8'(32'(A_CCR0) + 4 * ch);
  endfunction

  initial begin
    logic [31:0] v, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_CNT, v);  chk("R1 cnt", v, 0);
    rd(A_PSC, v);  chk("R1 psc", v, 0);
    rd(A_STAT, v); chk("R1 stat", v, 0);
    rd(ccr_addr(7), v); chk("R1 ccr7", v, 0);
    chk("R1 irq", {15'b0, upd_irq, ch_irq}, 0);
    @(negedge clk);

    // R2 R6 R7 R11 sweep over ratio, channel, mode
    for (int p = 0; p < 4; p++)
      for (int ch = 0; ch < NCH; ch++)
        for (int m = 0; m < 2; m++) begin
          int d;
          logic [15:0] pre;
          d = ch + p;
          pre = 16'hA000 | 16'(ch) | 16'(m << 8);
          wr(A_MODE, (m == 1) ? (32'd1 << ch) : 32'd0);
          wr(A_IE, 32'd1 << (ch + 1));
          wr(ccr_addr(ch), {16'b0, pre});
          wr(A_PSC, p);
          wr(A_EGR, 32'd1);
          idle(d);
          wr(A_EGR, 32'd1 << (ch + 1));
          rd(ccr_addr(ch), v);
          if (m == 1) chk("R6 R2 capture", v, d / (p + 1));
          else        chk("R7 no capture", v, {16'b0, pre});
          rd(A_STAT, v);
          chk("R6 R7 R3 flags", v, 32'd1 | (32'd1 << (ch + 1)));
          chk("R11 ch_irq", {16'b0, ch_irq}, 32'd1 << ch);
          chk("R11 upd_irq off", {31'b0, upd_irq}, 0);
          wr(A_STAT, 32'd0);
          rd(A_STAT, v); chk("R10 clear", v, 0);
          chk("R11 ch_irq low", {16'b0, ch_irq}, 0);
        end

    // R4 pending ratio ignored until update
    wr(A_MODE, 0);
    wr(A_PSC, 0);
    wr(A_EGR, 1);
    wr(A_PSC, 3);
    rd(A_CNT, c0);
    idle(8);
    rd(A_CNT, v); chk("R4 rate unchanged", v - c0, 8);
    rd(A_PSC, v); chk("R4 psc readback", v, 3);
    // R5 wrap applies pending ratio
    wr(A_PSC, 1);
    wr(A_STAT, 0);
    wr(A_CNT, 32'h0000_FFFE);
    rd(A_CNT, v); chk("R12 cnt write", v, 32'hFFFE);
    idle(2);
    rd(A_CNT, v);  chk("R5 wrap", v, 0);
    rd(A_STAT, v); chk("R5 wrap flag", v, 1);
    idle(4);
    rd(A_CNT, v);  chk("R4 ratio at wrap", v, 2);
    wr(A_IE, 1);
    chk("R11 upd_irq", {31'b0, upd_irq}, 1);

    // R10 hardware set beats software clear
    wr(A_PSC, 0);
    wr(A_EGR, 1);
    wr(A_STAT, 0);
    wr(A_CNT, 32'h0000_FFFF);
    wr(A_STAT, 0);
    rd(A_STAT, v); chk("R10 set wins", v, 1);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R10 write one keeps", v, 1);
    wr(A_STAT, 0);
    rd(A_STAT, v); chk("R10 clear after", v, 0);

    // R8 zero write and readback
    wr(A_CNT, 32'h0000_0100);
    wr(A_EGR, 0);
    rd(A_CNT, v);  chk("R8 no reset", v, 32'h101);
    rd(A_STAT, v); chk("R8 no flags", v, 0);
    rd(A_EGR, v);  chk("R8 reads zero", v, 0);

    // R9 simultaneous bits
    wr(A_MODE, 32'd1 << 3);
    wr(ccr_addr(5), 32'h5555);
    wr(A_CNT, 32'h1234);
    wr(A_EGR, 32'd1 | (32'd1 << 4) | (32'd1 << 6));
    rd(A_CNT, v);  chk("R9 update", v, 0);
    rd(ccr_addr(3), v); chk("R9 capture pre-reset", v, 32'h1234);
    rd(ccr_addr(5), v); chk("R9 output keeps", v, 32'h5555);
    rd(A_STAT, v); chk("R9 all flags", v, 32'h51);

    // R12 upper bits
    wr(A_CNT, 32'hFFFF_0005);
    rd(A_CNT, v);  chk("R12 upper zero", v, 32'h5);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule